// File: doc/BRIEF.md
# Prioritized Sample Sequencer Trigger Arbiter

This block sits in front of a shared analog-to-digital converter that serves four sample sequencers. Each sequencer picks its own trigger source through a 3-bit selector. The choices are a software initiate strobe, a comparator event, a rising edge on an external pin, a timer event, and an always-on continuous mode. A trigger seen by an enabled sequencer is latched as pending. The converter is then granted to exactly one pending sequencer at a time.

Selection uses a 2-bit priority per sequencer, where 0 is the most urgent. Equal values are resolved toward the lower index. A flag reports when two enabled sequencers share a priority value, which is a configuration error. A grant is held until the converter pulses done. That done pulse clears the pending trigger, but a continuous-mode sequencer re-arms at once. Such a sequencer at high priority can therefore hold the converter against all others.

Top module: `sqarb_top`

## Requirements
- R1: While rst_ni is low, grant_o, grant_vld_o, grant_idx_o and pend_o are all zero.
- R2: Selector codes per sequencer (3 bits, sequencer i at bits 3i+2..3i of src_sel_i) are: 0 software initiate, 1 comparator, 2 external pin rising edge, 3 timer, 4 continuous, and 5 to 7 no trigger at all.
- R3: A one-cycle strobe on sw_init_i[i] sets an initiate bit that clears itself one cycle later. The strobe therefore gives exactly one pending event, visible on pend_o two clock edges after the strobe is sampled.
- R4: An external-pin sequencer triggers only on a low-to-high transition of ext_pin_i. Holding the pin high produces one event.
- R5: A sequencer with seq_en_i[i] low never becomes pending, whatever its source does, and it is never granted.
- R6: At each arbitration, the pending enabled sequencer with the numerically lowest priority value (sequencer i at bits 2i+1..2i of prio_i) is granted.
- R7: Among pending sequencers with equal priority, the lowest index wins.
- R8: dup_prio_o is high, combinationally, exactly when two or more enabled sequencers hold the same priority value.
- R9: grant_o is one-hot with grant_idx_o matching while grant_vld_o is high, and all-zero otherwise. A grant is issued one edge after a pending trigger exists, only when no grant is active and conv_busy_i is low. It holds unchanged until conv_done_i.
- R10: conv_done_i during a grant drops the grant and clears that sequencer's pending bit at the same edge. A continuous-mode sequencer stays pending. The next grant can follow one edge later.
- R11: A continuous-mode sequencer of higher priority is granted at every arbitration, while a lower-priority pending sequencer waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seq_en_i | input | N | Per-sequencer enable |
| src_sel_i | input | 3*N | Per-sequencer trigger source code |
| prio_i | input | 2*N | Per-sequencer priority, 0 most urgent |
| sw_init_i | input | N | Software initiate write strobes |
| cmp_evt_i | input | 1 | Comparator event |
| ext_pin_i | input | 1 | External trigger pin level |
| tmr_evt_i | input | 1 | Timer event |
| conv_busy_i | input | 1 | Converter busy, blocks new grants |
| conv_done_i | input | 1 | Converter finished the granted sequence |
| grant_o | output | N | One-hot grant |
| grant_idx_o | output | log2(N) | Index of the granted sequencer |
| grant_vld_o | output | 1 | A grant is active |
| pend_o | output | N | Pending trigger bits |
| dup_prio_o | output | 1 | Two enabled sequencers share a priority |

## Verification
The main sweep covers every one of the 256 priority assignments together with every non-empty set of simultaneous software triggers. Each case is drained grant by grant, and every grant is compared with an order computed from priority and then index. This separates a wrong comparison direction from a wrong tie rule and from a pending bit that is not cleared. A second sweep crosses all priority assignments with all enable masks to pin down the duplicate flag. Directed runs then drive each remaining source on its own, including the held pin and the unused codes. Further runs hold busy, try a pre-empting trigger during a grant, and let a continuous sequencer starve a lower one until its source is switched off.

// File: rtl/sqarb_pkg.sv
package sqarb_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_SW   = 3'd0,
    SRC_CMP  = 3'd1,
    SRC_EXT  = 3'd2,
    SRC_TMR  = 3'd3,
    SRC_CONT = 3'd4
  } src_e;
endpackage

// File: rtl/sqarb_trig_sel.sv
module sqarb_trig_sel
  import sqarb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N*SEL_W-1:0] sel_i,
  input  logic [N-1:0]       sw_i,
  input  logic               cmp_i,
  input  logic               ext_rise_i,
  input  logic               tmr_i,
  output logic [N-1:0]       trig_o
);
  for (genvar g = 0; g < N; g++) begin : g_seq
    logic [SEL_W-1:0] s;
    logic             t;
    assign s = sel_i[g*SEL_W +: SEL_W];
    always_comb begin
      case (s)
        SRC_SW:   t = sw_i[g];
        SRC_CMP:  t = cmp_i;
        SRC_EXT:  t = ext_rise_i;
        SRC_TMR:  t = tmr_i;
        SRC_CONT: t = 1'b1;
        default:  t = 1'b0;
      endcase
    end
    assign trig_o[g] = t;
  end
endmodule

// File: rtl/sqarb_pend.sv
module sqarb_pend #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] set;

  assign set = trig_i & en_i;

  // set wins over clear so continuous mode re-arms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set;
  end

  assign pend_o = pend_q;

  // R5
  pend_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q) & ~$past(en_i)) == '0));

  // R10
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set) != '0) |=> ((pend_q & $past(clr_i & ~set)) == '0));
endmodule

// File: rtl/sqarb_pick.sv
module sqarb_pick #(
  parameter int N      = 4,
  parameter int PRIO_W = 2,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]        elig_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                any_o,
  output logic [IDX_W-1:0]    win_o
);
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lower index on ties
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] < best)) begin
        any_o = 1'b1;
        win_o = IDX_W'(i);
        best  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/sqarb_dup.sv
module sqarb_dup #(
  parameter int N      = 4,
  parameter int PRIO_W = 2
) (
  input  logic [N-1:0]        en_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                dup_o
);
  always_comb begin
    dup_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (en_i[i] && en_i[j] &&
            prio_i[i*PRIO_W +: PRIO_W] == prio_i[j*PRIO_W +: PRIO_W])
          dup_o = 1'b1;
      end
    end
  end

  always_comb begin
    // R8
    if ($countones(en_i) <= 1) dup_single_chk: assert (!dup_o);
  end
endmodule

// File: rtl/sqarb_top.sv
module sqarb_top
  import sqarb_pkg::*;
#(
  parameter int N      = 4,
  parameter int PRIO_W = 2,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        seq_en_i,
  input  logic [N*SEL_W-1:0]  src_sel_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  input  logic [N-1:0]        sw_init_i,
  input  logic                cmp_evt_i,
  input  logic                ext_pin_i,
  input  logic                tmr_evt_i,
  input  logic                conv_busy_i,
  input  logic                conv_done_i,
  output logic [N-1:0]        grant_o,
  output logic [IDX_W-1:0]    grant_idx_o,
  output logic                grant_vld_o,
  output logic [N-1:0]        pend_o,
  output logic                dup_prio_o
);
  logic [N-1:0]     sw_q;
  logic             ext_q;
  logic             ext_rise;
  logic [N-1:0]     trig;
  logic [N-1:0]     pend;
  logic [N-1:0]     elig;
  logic [N-1:0]     clr;
  logic             any;
  logic [IDX_W-1:0] win;
  logic             issue;
  logic             fin;
  logic [N-1:0]     gnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             vld_q;

  // initiate bits self-clear after one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= '0;
      ext_q <= 1'b0;
    end else begin
      sw_q  <= sw_init_i;
      ext_q <= ext_pin_i;
    end
  end

  assign ext_rise = ext_pin_i & ~ext_q;

  sqarb_trig_sel #(.N(N)) u_trig (
    .sel_i      (src_sel_i),
    .sw_i       (sw_q),
    .cmp_i      (cmp_evt_i),
    .ext_rise_i (ext_rise),
    .tmr_i      (tmr_evt_i),
    .trig_o     (trig)
  );

  assign fin = vld_q & conv_done_i;
  assign clr = fin ? gnt_q : '0;

  sqarb_pend #(.N(N)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig),
    .en_i   (seq_en_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  assign elig = pend & seq_en_i;

  sqarb_pick #(.N(N), .PRIO_W(PRIO_W)) u_pick (
    .elig_i (elig),
    .prio_i (prio_i),
    .any_o  (any),
    .win_o  (win)
  );

  sqarb_dup #(.N(N), .PRIO_W(PRIO_W)) u_dup (
    .en_i   (seq_en_i),
    .prio_i (prio_i),
    .dup_o  (dup_prio_o)
  );

  assign issue = !vld_q && !conv_busy_i && any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      gnt_q <= '0;
      idx_q <= '0;
    end else if (fin) begin
      vld_q <= 1'b0;
      gnt_q <= '0;
    end else if (issue) begin
      vld_q <= 1'b1;
      gnt_q <= N'(1) << win;
      idx_q <= win;
    end
  end

  assign grant_o     = gnt_q;
  assign grant_idx_o = idx_q;
  assign grant_vld_o = vld_q;
  assign pend_o      = pend;

  // independent check that no eligible rival beats the chosen winner
  logic [PRIO_W-1:0] win_p;
  logic              better;
  always_comb begin
    win_p  = prio_i[int'(win)*PRIO_W +: PRIO_W];
    better = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (elig[j] && (prio_i[j*PRIO_W +: PRIO_W] < win_p ||
          (prio_i[j*PRIO_W +: PRIO_W] == win_p && j < int'(win))))
        better = 1'b1;
    end
  end

  // R6
  best_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |-> (!better && elig[win]));

  // R9
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q ? (gnt_q == (N'(1) << idx_q)) : (gnt_q == '0));

  // R9
  grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !conv_done_i) |=> (vld_q && $stable(gnt_q)));

  // R9
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_q && conv_busy_i) |=> !vld_q);

  // R10
  done_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> !vld_q);
endmodule

// File: tb/sqarb_top_test.sv
`timescale 1ns/1ps
module sqarb_top_test;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  en = '0;
  logic [11:0] sel = '0;
  logic [7:0]  prio = '0;
  logic [3:0]  sw = '0;
  logic        cmp = 1'b0, ext = 1'b0, tmr = 1'b0, busy = 1'b0, done = 1'b0;
  logic [3:0]  grant;
  logic [1:0]  gidx;
  logic        gvld;
  logic [3:0]  pend;
  logic        dup;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sqarb_top #(.N(N), .PRIO_W(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .seq_en_i(en), .src_sel_i(sel), .prio_i(prio),
    .sw_init_i(sw), .cmp_evt_i(cmp), .ext_pin_i(ext), .tmr_evt_i(tmr),
    .conv_busy_i(busy), .conv_done_i(done), .grant_o(grant), .grant_idx_o(gidx),
    .grant_vld_o(gvld), .pend_o(pend), .dup_prio_o(dup)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = '0; sel = '0; prio = '0; sw = '0;
    cmp = 0; ext = 0; tmr = 0; busy = 0; done = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  function automatic int pick(logic [7:0] pr, logic [3:0] m);
    int b = -1;
    for (int i = 0; i < 4; i++)
      if (m[i] && (b < 0 || pr[i*2 +: 2] < pr[b*2 +: 2])) b = i;
    return b;
  endfunction

  function automatic bit exp_dup(logic [7:0] pr, logic [3:0] m);
    for (int i = 0; i < 4; i++)
      for (int j = i + 1; j < 4; j++)
        if (m[i] && m[j] && pr[i*2 +: 2] == pr[j*2 +: 2]) return 1'b1;
    return 1'b0;
  endfunction

  // grant expected to appear at the next edge; then complete it
  task automatic serve(input string req, input int exp_idx);
    tick();
    chk({req, " grant valid"}, 32'(gvld), 32'd1);
    chk({req, " grant idx"}, 32'(gidx), 32'(exp_idx));
    chk({req, " grant onehot"}, 32'(grant), 32'(4'b1 << exp_idx));
    done = 1'b1;
    tick();
    done = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick();
    chk("R1 grant", 32'(grant), 0);
    chk("R1 vld", 32'(gvld), 0);
    chk("R1 idx", 32'(gidx), 0);
    chk("R1 pend", 32'(pend), 0);
    do_reset();

    // R6 R7 R3 R10 sweep: all priorities x all software trigger masks
    en = 4'hF;
    for (int pv = 0; pv < 256; pv++) begin
      for (int m = 1; m < 16; m++) begin
        logic [3:0] rem;
        prio = 8'(pv);
        sw = 4'(m);
        tick();
        sw = '0;
        tick();
        chk("R3 pend after strobe", 32'(pend), 32'(m));
        rem = 4'(m);
        while (rem != 0) begin
          int e;
          e = pick(8'(pv), rem);
          serve("R6 R7 order", e);
          rem[e] = 1'b0;
          chk("R10 grant dropped", 32'(gvld), 0);
          chk("R10 pend cleared", 32'(pend), 32'(rem));
        end
      end
    end

    // R8 sweep: all priorities x all enable masks, no triggers
    do_reset();
    sel = {4{3'd5}};
    for (int pv = 0; pv < 256; pv++) begin
      for (int m = 0; m < 16; m++) begin
        prio = 8'(pv);
        en = 4'(m);
        #1;
        chk("R8 dup flag", 32'(dup), 32'(exp_dup(8'(pv), 4'(m))));
      end
    end
    tick();

    // R4 external pin held high gives one event
    do_reset();
    en = 4'b0001; sel = {3'd0, 3'd0, 3'd0, 3'd2};
    ext = 1'b1;
    tick();
    chk("R4 pend on rise", 32'(pend), 1);
    serve("R4", 0);
    tick(); tick();
    chk("R4 no retrigger while high", 32'(pend), 0);
    chk("R4 no regrant", 32'(gvld), 0);
    ext = 1'b0;

    // R2 comparator and timer codes
    do_reset();
    en = 4'b0110; sel = {3'd0, 3'd3, 3'd1, 3'd0}; prio = 8'b00_01_00_00;
    cmp = 1'b1;
    tick();
    cmp = 1'b0;
    chk("R2 comparator source", 32'(pend), 32'b0010);
    serve("R2 comparator", 1);
    tmr = 1'b1;
    tick();
    tmr = 1'b0;
    chk("R2 timer source", 32'(pend), 32'b0100);
    serve("R2 timer", 2);

    // R2 codes 5..7 never trigger
    do_reset();
    en = 4'hF; sel = {3'd7, 3'd6, 3'd5, 3'd5}; prio = 8'b11_10_01_00;
    sw = 4'hF; cmp = 1; tmr = 1; ext = 1;
    tick();
    sw = '0; cmp = 0; tmr = 0; ext = 0;
    tick(); tick();
    chk("R2 unused codes pend", 32'(pend), 0);
    chk("R2 unused codes grant", 32'(gvld), 0);

    // R5 disabled sequencers ignore continuous and software triggers
    do_reset();
    en = 4'b0000; sel = {3'd4, 3'd4, 3'd0, 3'd4};
    sw = 4'b0010;
    tick();
    sw = '0;
    tick(); tick(); tick();
    chk("R5 disabled pend", 32'(pend), 0);
    chk("R5 disabled grant", 32'(gvld), 0);

    // R9 busy blocks issue; grant holds against a higher-priority arrival
    do_reset();
    en = 4'hF; sel = '0; prio = 8'b00_01_10_11; busy = 1'b1;
    sw = 4'b0001;
    tick();
    sw = '0;
    tick();
    chk("R3 pend", 32'(pend), 1);
    tick(); tick();
    chk("R9 busy blocks grant", 32'(gvld), 0);
    busy = 1'b0;
    tick();
    chk("R9 grant after busy", 32'(gvld), 1);
    chk("R9 grant idx", 32'(gidx), 0);
    sw = 4'b1000;
    tick();
    sw = '0;
    tick(); tick();
    chk("R9 grant held", 32'(grant), 32'b0001);
    chk("R9 pending waits", 32'(pend), 32'b1001);
    done = 1'b1;
    tick();
    done = 1'b0;
    serve("R9 next", 3);

    // R11 continuous high-priority sequencer starves a lower one
    do_reset();
    en = 4'b0011; sel = {3'd0, 3'd0, 3'd0, 3'd4}; prio = 8'b00_00_01_00;
    sw = 4'b0010;
    tick();
    sw = '0;
    for (int k = 0; k < 5; k++) begin
      serve("R11 starve", 0);
      chk("R10 continuous re-armed", 32'(pend), 32'b0011);
    end
    tick();
    sel = {3'd0, 3'd0, 3'd0, 3'd5};
    chk("R11 grant again", 32'(gidx), 0);
    done = 1'b1;
    tick();
    done = 1'b0;
    chk("R10 cleared after source off", 32'(pend), 32'b0010);
    serve("R11 released", 1);
    chk("R10 all clear", 32'(pend), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule